// File: doc/BRIEF.md
# Ballot Tally Collator with Outcome Decision

This block tallies a chamber vote once the voting window has closed. Each seat terminal presents four held flags: accredited, nullified, for and against. A single collate request starts a serial scan. A shared seat address walks from seat 0 up to the last seat, and four category selectors pick each seat's flag in turn. Every asserted flag bumps its own decimal (BCD) tally, so the totals can go straight to numeric displays without conversion.

When the scan finishes, the block compares the for tally with the against tally. It raises exactly one of three outcome lines: passed, failed or tied. Together with the outcome it raises a done indication and starts a blink enable for the results board, with a half period of `FLASH_HALF_TICKS` clock cycles (half the clock rate gives 1 Hz). It also issues a one-cycle tune trigger, but only for a passed motion. A saturating overflow flag warns when a tally ran out of digits. Each new collate request clears every tally, the outcome, the done indication and the overflow flag.

Top module: `ballot_collator`

## Requirements
- R1: Out of reset all four tallies read zero, and busy, done, the three outcome lines, overflow, blink and tune trigger are all low.
- R2: A collate request sampled at clock edge k while the block is idle or done makes busy high from edge k. Busy falls and done rises at edge k+NUM_SEATS+1, and done stays high until the next accepted request.
- R3: After the scan, each tally equals the number of seats whose flag in that category is high. It is coded as DIGITS BCD digits with digit i in bits 4i+3..4i, and it saturates at all nines.
- R4: Overflow goes high when any tally would have gone past all nines, and it stays high until the next accepted request.
- R5: While done is high, exactly one outcome line is high: passed if the for tally exceeds the against tally, failed if it is below, tied if they are equal. The compare uses the tallies as shown. While done is low, all three outcome lines are low.
- R6: The tune trigger is high for exactly the first done cycle when the outcome is passed, and is never high otherwise.
- R7: Blink is low while done is low. It goes high with done and then inverts every FLASH_HALF_TICKS cycles.
- R8: An accepted request clears tallies, outcome, overflow, done and blink at edge k. A request that arrives while busy is ignored and does not disturb the running scan or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| collateStart | input | 1 | Collate request, sampled each edge |
| accredFlags | input | NUM_SEATS | Per-seat accredited flags |
| nullFlags | input | NUM_SEATS | Per-seat nullified flags |
| forFlags | input | NUM_SEATS | Per-seat for flags |
| againstFlags | input | NUM_SEATS | Per-seat against flags |
| accredTotal | output | 4*DIGITS | BCD tally of accredited seats |
| nullTotal | output | 4*DIGITS | BCD tally of nullified seats |
| forTotal | output | 4*DIGITS | BCD tally of for votes |
| againstTotal | output | 4*DIGITS | BCD tally of against votes |
| collateBusy | output | 1 | Scan or decision in progress |
| collateDone | output | 1 | Tallies and outcome valid |
| motionPassed | output | 1 | For exceeds against |
| motionFailed | output | 1 | Against exceeds for |
| motionTied | output | 1 | For equals against |
| tallyOverflow | output | 1 | A tally saturated |
| flashOn | output | 1 | Results blink enable |
| tuneStart | output | 1 | One-cycle trigger on a passed outcome |

## Verification
The assertions assume that the four flag vectors do not change on any cycle after the first busy cycle until busy falls, because the serial scan reads each seat only once. The stimulus therefore sets all flags before raising the collate request and leaves them alone until done is high. It still raises a second request in the middle of a scan, to show that the request is ignored. The sweep uses twelve seats and one digit, so tallies of ten and more reach saturation and the compare runs on saturated values.

// File: rtl/ballot_pkg.sv
package ballot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_DECIDE = 2'd2,
    ST_DONE   = 2'd3
  } collate_state_t;

  typedef struct packed {
    logic clear;
    logic sample;
    logic decide;
  } collate_strobe_t;

  localparam int CAT_ACCRED  = 0;
  localparam int CAT_NULL    = 1;
  localparam int CAT_FOR     = 2;
  localparam int CAT_AGAINST = 3;
  localparam int NUM_CATS    = 4;

endpackage

// File: rtl/bcd_tally.sv
module bcd_tally #(
  parameter int DIGITS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clear,
  input  logic                  inc,
  output logic [4*DIGITS-1:0]   count,
  output logic                  saturated
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0]    nextCount;
  logic [DIGITS:0] carry;

  // decimal ripple increment, digit 0 least significant
  always_comb begin
    nextCount = count;
    carry[0]  = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (carry[d]) begin
        if (count[4*d +: 4] == 4'd9) begin
          nextCount[4*d +: 4] = 4'd0;
          carry[d+1] = 1'b1;
        end else begin
          nextCount[4*d +: 4] = count[4*d +: 4] + 4'd1;
          carry[d+1] = 1'b0;
        end
      end else begin
        carry[d+1] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      saturated <= 1'b0;
    end else if (clear) begin
      count     <= '0;
      saturated <= 1'b0;
    end else if (inc) begin
      if (carry[DIGITS]) saturated <= 1'b1;
      else               count     <= nextCount;
    end
  end

  // R4: saturation is sticky until cleared
  p_sat_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (saturated && !clear) |=> saturated);

  // R3: a saturated tally never moves
  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (saturated && !clear) |=> $stable(count));

  // R8: clear empties the tally
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (count == '0 && !saturated));

endmodule

// File: rtl/ballot_ctrl.sv
module ballot_ctrl
  import ballot_pkg::*;
#(
  parameter int NUM_SEATS        = 5,
  parameter int FLASH_HALF_TICKS = 50_000_000,
  localparam int ADDR_W  = (NUM_SEATS > 1) ? $clog2(NUM_SEATS) : 1,
  localparam int FLASH_W = $clog2(FLASH_HALF_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              collateStart,
  output collate_strobe_t   strobe,
  output logic [ADDR_W-1:0] seatAddr,
  output logic              busy,
  output logic              done,
  output logic              flashOn
);
  localparam logic [ADDR_W-1:0]  LAST_SEAT  = ADDR_W'(NUM_SEATS - 1);
  localparam logic [FLASH_W-1:0] FLASH_LAST = FLASH_W'(FLASH_HALF_TICKS - 1);

  collate_state_t     state;
  logic [FLASH_W-1:0] flashCnt;
  logic               accept;

  assign accept = collateStart && (state == ST_IDLE || state == ST_DONE);

  always_comb begin
    strobe.clear  = accept;
    strobe.sample = (state == ST_SCAN);
    strobe.decide = (state == ST_DECIDE);
  end

  assign busy = (state == ST_SCAN) || (state == ST_DECIDE);
  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      seatAddr <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (collateStart) begin
            state    <= ST_SCAN;
            seatAddr <= '0;
          end
        end
        ST_SCAN: begin
          if (seatAddr == LAST_SEAT) state <= ST_DECIDE;
          else                       seatAddr <= seatAddr + 1'b1;
        end
        ST_DECIDE: state <= ST_DONE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // results blink: starts lit together with done
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashOn  <= 1'b0;
      flashCnt <= '0;
    end else if (accept) begin
      flashOn  <= 1'b0;
      flashCnt <= '0;
    end else if (state == ST_DECIDE) begin
      flashOn  <= 1'b1;
      flashCnt <= '0;
    end else if (state == ST_DONE) begin
      if (flashCnt == FLASH_LAST) begin
        flashCnt <= '0;
        flashOn  <= ~flashOn;
      end else begin
        flashCnt <= flashCnt + 1'b1;
      end
    end
  end

  // R2: address never leaves the seat range during a scan
  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> (seatAddr <= LAST_SEAT));

  // R8: a request during busy leaves the scan running
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && seatAddr != LAST_SEAT) |=> (state == ST_SCAN));

  // R7: blink is dark outside the done state
  p_flash_dark_r7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !flashOn);

endmodule

// File: rtl/ballot_dp.sv
module ballot_dp
  import ballot_pkg::*;
#(
  parameter int NUM_SEATS = 5,
  parameter int DIGITS    = 2,
  localparam int ADDR_W   = (NUM_SEATS > 1) ? $clog2(NUM_SEATS) : 1,
  localparam int W        = 4 * DIGITS
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  collate_strobe_t                    strobe,
  input  logic [ADDR_W-1:0]                  seatAddr,
  input  logic [NUM_CATS-1:0][NUM_SEATS-1:0] flagsAll,
  output logic [NUM_CATS-1:0][W-1:0]         tallies,
  output logic                               passed,
  output logic                               failed,
  output logic                               tied,
  output logic                               overflow,
  output logic                               tuneStart
);
  logic [NUM_CATS-1:0] satVec;
  logic                forAhead;
  logic                forBehind;

  for (genvar c = 0; c < NUM_CATS; c++) begin : g_cat
    logic hit;
    assign hit = strobe.sample & flagsAll[c][seatAddr];
    bcd_tally #(.DIGITS(DIGITS)) u_tally (
      .clk       (clk),
      .rstN      (rstN),
      .clear     (strobe.clear),
      .inc       (hit),
      .count     (tallies[c]),
      .saturated (satVec[c])
    );
  end

  // valid BCD of equal width orders like the values it codes
  assign forAhead  = tallies[CAT_FOR] > tallies[CAT_AGAINST];
  assign forBehind = tallies[CAT_FOR] < tallies[CAT_AGAINST];
  assign overflow  = |satVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passed    <= 1'b0;
      failed    <= 1'b0;
      tied      <= 1'b0;
      tuneStart <= 1'b0;
    end else begin
      tuneStart <= strobe.decide && forAhead;
      if (strobe.clear) begin
        passed <= 1'b0;
        failed <= 1'b0;
        tied   <= 1'b0;
      end else if (strobe.decide) begin
        passed <= forAhead;
        failed <= forBehind;
        tied   <= !forAhead && !forBehind;
      end
    end
  end

  // R5: a settled outcome stays put until the next clear or decide
  p_outcome_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.decide) |=> $stable({passed, failed, tied}));

  // R6: the trigger never lasts two cycles
  p_tune_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    tuneStart |=> !tuneStart);

endmodule

// File: rtl/ballot_collator.sv
module ballot_collator
  import ballot_pkg::*;
#(
  parameter int NUM_SEATS        = 5,
  parameter int DIGITS           = 2,
  parameter int FLASH_HALF_TICKS = 50_000_000,
  localparam int ADDR_W = (NUM_SEATS > 1) ? $clog2(NUM_SEATS) : 1,
  localparam int W      = 4 * DIGITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 collateStart,
  input  logic [NUM_SEATS-1:0] accredFlags,
  input  logic [NUM_SEATS-1:0] nullFlags,
  input  logic [NUM_SEATS-1:0] forFlags,
  input  logic [NUM_SEATS-1:0] againstFlags,
  output logic [W-1:0]         accredTotal,
  output logic [W-1:0]         nullTotal,
  output logic [W-1:0]         forTotal,
  output logic [W-1:0]         againstTotal,
  output logic                 collateBusy,
  output logic                 collateDone,
  output logic                 motionPassed,
  output logic                 motionFailed,
  output logic                 motionTied,
  output logic                 tallyOverflow,
  output logic                 flashOn,
  output logic                 tuneStart
);
  collate_strobe_t                    strobe;
  logic [ADDR_W-1:0]                  seatAddr;
  logic [NUM_CATS-1:0][NUM_SEATS-1:0] flagsAll;
  logic [NUM_CATS-1:0][W-1:0]         tallies;

  assign flagsAll[CAT_ACCRED]  = accredFlags;
  assign flagsAll[CAT_NULL]    = nullFlags;
  assign flagsAll[CAT_FOR]     = forFlags;
  assign flagsAll[CAT_AGAINST] = againstFlags;

  assign accredTotal  = tallies[CAT_ACCRED];
  assign nullTotal    = tallies[CAT_NULL];
  assign forTotal     = tallies[CAT_FOR];
  assign againstTotal = tallies[CAT_AGAINST];

  ballot_ctrl #(
    .NUM_SEATS        (NUM_SEATS),
    .FLASH_HALF_TICKS (FLASH_HALF_TICKS)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .collateStart (collateStart),
    .strobe       (strobe),
    .seatAddr     (seatAddr),
    .busy         (collateBusy),
    .done         (collateDone),
    .flashOn      (flashOn)
  );

  ballot_dp #(
    .NUM_SEATS (NUM_SEATS),
    .DIGITS    (DIGITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .seatAddr  (seatAddr),
    .flagsAll  (flagsAll),
    .tallies   (tallies),
    .passed    (motionPassed),
    .failed    (motionFailed),
    .tied      (motionTied),
    .overflow  (tallyOverflow),
    .tuneStart (tuneStart)
  );

  // R5: one outcome while done
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rstN)
    collateDone |-> $onehot({motionPassed, motionFailed, motionTied}));

  // R5: no outcome while not done
  p_no_outcome_r5: assert property (@(posedge clk) disable iff (!rstN)
    !collateDone |-> ({motionPassed, motionFailed, motionTied} == 3'b000));

  // R6: trigger only with a passed, finished collation
  p_tune_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    tuneStart |-> (collateDone && motionPassed));

  // R2: busy and done never overlap
  p_busy_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(collateBusy && collateDone));

  // R3: input assumption, flags held during the scan
  p_flags_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (collateBusy && $past(collateBusy)) |->
      $stable({accredFlags, nullFlags, forFlags, againstFlags}));

endmodule

// File: tb/sim_ballot_collator.sv
`timescale 1ns/1ps
module sim_ballot_collator;
  localparam int N = 12;
  localparam int D = 1;
  localparam int H = 3;
  localparam int W = 4 * D;
  localparam int MAXV = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic collateStart = 1'b0;
  logic [N-1:0] accredFlags = '0, nullFlags = '0, forFlags = '0, againstFlags = '0;
  logic [W-1:0] accredTotal, nullTotal, forTotal, againstTotal;
  logic collateBusy, collateDone, motionPassed, motionFailed, motionTied;
  logic tallyOverflow, flashOn, tuneStart;

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ballot_collator #(.NUM_SEATS(N), .DIGITS(D), .FLASH_HALF_TICKS(H)) u0 (
    .clk(clk), .rstN(rstN), .collateStart(collateStart),
    .accredFlags(accredFlags), .nullFlags(nullFlags),
    .forFlags(forFlags), .againstFlags(againstFlags),
    .accredTotal(accredTotal), .nullTotal(nullTotal),
    .forTotal(forTotal), .againstTotal(againstTotal),
    .collateBusy(collateBusy), .collateDone(collateDone),
    .motionPassed(motionPassed), .motionFailed(motionFailed),
    .motionTied(motionTied), .tallyOverflow(tallyOverflow),
    .flashOn(flashOn), .tuneStart(tuneStart)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bcdVal(input logic [W-1:0] x);
    int v = 0;
    for (int d = D - 1; d >= 0; d--) v = v * 10 + int'(x[4*d +: 4]);
    return v;
  endfunction

  function automatic logic [N-1:0] spread(input int cnt, input int rot);
    logic [N-1:0] m = '0;
    for (int i = 0; i < cnt; i++) m[(i + rot) % N] = 1'b1;
    return m;
  endfunction

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic runVote(input int f, input int a, input int acc, input int nul,
                         input bit mid, input bit seeFlash);
    int ef, ea, outc, gotOut;
    bit eo;
    @(negedge clk);
    forFlags     = spread(f, 0);
    againstFlags = spread(a, N - a);
    accredFlags  = spread(acc, 5);
    nullFlags    = spread(nul, 2);
    collateStart = 1'b1;
    @(negedge clk);
    collateStart = 1'b0;
    // after accept edge k
    chk(collateBusy == 1'b1 && collateDone == 1'b0, "R2 busy at start", int'(collateBusy), 1);
    chk(forTotal == '0 && againstTotal == '0 && accredTotal == '0 && nullTotal == '0 && !tallyOverflow,
        "R8 clear at start", bcdVal(forTotal), 0);
    chk(flashOn == 1'b0, "R7 blink dark while scanning", int'(flashOn), 0);
    chk({motionPassed, motionFailed, motionTied} == 3'b000, "R5 no outcome while busy",
        int'({motionPassed, motionFailed, motionTied}), 0);
    for (int i = 1; i <= N; i++) begin
      @(negedge clk);
      collateStart = (mid && i == 2);
    end
    chk(collateDone == 1'b0 && collateBusy == 1'b1, "R2 still busy at edge k+N",
        int'(collateDone), 0);
    @(negedge clk);
    collateStart = 1'b0;
    // after edge k+N+1
    ef = sat(f); ea = sat(a);
    eo = (f > MAXV) || (a > MAXV) || (acc > MAXV) || (nul > MAXV);
    outc = (ef > ea) ? 4 : ((ef < ea) ? 2 : 1);
    gotOut = int'({motionPassed, motionFailed, motionTied});
    chk(collateDone == 1'b1 && collateBusy == 1'b0, "R2 done at edge k+N+1", int'(collateDone), 1);
    chk(bcdVal(forTotal) == ef, "R3 for tally", bcdVal(forTotal), ef);
    chk(bcdVal(againstTotal) == ea, "R3 against tally", bcdVal(againstTotal), ea);
    chk(bcdVal(accredTotal) == sat(acc), "R3 accredited tally", bcdVal(accredTotal), sat(acc));
    chk(bcdVal(nullTotal) == sat(nul), "R3 nullified tally", bcdVal(nullTotal), sat(nul));
    chk(tallyOverflow == eo, "R4 overflow flag", int'(tallyOverflow), int'(eo));
    chk(gotOut == outc, "R5 outcome", gotOut, outc);
    chk(tuneStart == (outc == 4), "R6 tune on done", int'(tuneStart), int'(outc == 4));
    chk(flashOn == 1'b1, "R7 blink lit with done", int'(flashOn), 1);
    @(negedge clk);
    chk(tuneStart == 1'b0, "R6 tune one cycle", int'(tuneStart), 0);
    chk(collateDone == 1'b1 && int'({motionPassed, motionFailed, motionTied}) == outc,
        "R5 outcome held", int'({motionPassed, motionFailed, motionTied}), outc);
    if (seeFlash) begin
      for (int j = 1; j <= 2 * H + 1; j++) begin
        bit ex;
        ex = ((j / H) % 2) == 0;
        chk(flashOn == ex, "R7 blink cadence", int'(flashOn), int'(ex));
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vecs++; errs++;
      $display("FAIL watchdog run hung actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(forTotal == '0 && againstTotal == '0 && accredTotal == '0 && nullTotal == '0,
        "R1 tallies zero in reset", bcdVal(forTotal), 0);
    chk({collateBusy, collateDone, motionPassed, motionFailed, motionTied,
         tallyOverflow, flashOn, tuneStart} == 8'h00, "R1 controls low in reset",
        int'({collateBusy, collateDone, motionPassed, motionFailed, motionTied,
              tallyOverflow, flashOn, tuneStart}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(collateBusy == 1'b0 && collateDone == 1'b0, "R1 idle after reset", int'(collateBusy), 0);
    for (int f = 0; f <= N; f++) begin
      for (int a = 0; a <= N; a++) begin
        runVote(f, a, (f + a) % (N + 1), (3 * f + a) % (N + 1),
                ((f + a) % 5) == 0, (f == a) || ((f * a) % 7 == 1));
      end
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule